// File: doc/BRIEF.md
# Touch Keypad Host Command Handler

This block sits between a byte-wide serial link to a host and the sensing core of a 32-key touch matrix laid out as 8 X rows by 4 Y columns. It decodes a stream of short commands that carry no terminator. Each command is either a single character or a lead character followed by raw binary operands. The block answers with binary or ASCII response bytes. Through these commands the host reads the touch and fault vectors, per-key analog levels and calibration values, a fixed signature, and the four input pins. It also sets the eight output pins, and reads or writes a 256-byte table of per-key gain/threshold settings and free user storage.

Key (X, Y) uses zero-based X in 0..7 and Y in 0..3. Its flat index is Y*8 + X, both in the 32-bit vectors and on the per-key lookup port. The sensing core answers a lookup combinationally. Response bytes enter a queue in command order and leave one per accepted transmit handshake. A partial command is dropped when the host goes quiet for longer than a parameterised timeout.

Top module: `keypad_cmd_handler`

## Requirements
- R1: After reset tx_valid, recal_req and out_pins are all zero, rx_ready is high, and every byte of the settings table reads 0x00.
- R2: Byte 0x73 returns 4 bytes; byte k (k = 0..3, column k) equals touch_state[8k+7:8k], so bit b of byte k is key X=b, Y=k.
- R3: Byte 0x65 received as a first byte returns 4 bytes of key_error in the same byte and bit order as R2.
- R4: Byte 0x53 returns 7 bytes: 0x33 0x32 0x30 0x30 0x30, then REV_HI, then REV_LO.
- R5: 0x2F 0x64 X Y returns key_ref then key_sig of key {Y[1:0], X[2:0]}; key_sel shows that index in the cycle the Y byte is accepted, and the upper operand bits are ignored.
- R6: 0x2F 0x44 X Y returns key_offset, then a byte holding key_coarse in bits 1..0 and zeros above.
- R7: 0x2F 0x45 A v stores v at address A; 0x2F 0x65 A returns the one byte at A; every address 0..255 is writable and readable.
- R8: A write to an even address in 100..162 (a gain byte, at 100 + 2*X + 16*Y zero-based) raises recal_req for exactly one cycle, the cycle after v is accepted. A write to any other address (thresholds, 164..255) leaves recal_req low.
- R9: 0x4F v drives v on out_pins from the cycle after v is accepted; byte 0x49 returns {4'b0000, in_pins}.
- R10: An unknown first byte, or an unknown byte after 0x2F, produces no response and returns the parser to idle.
- R11: If a partial command sees no accepted byte for TIMEOUT_CYCLES cycles, it is abandoned and the next byte is decoded as a new command. A shorter gap continues the command.
- R12: Response bytes leave in command order. While tx_valid is high and tx_ready low, tx_data holds. rx_ready is low whenever fewer than 7 queue entries are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Handler can take a byte |
| tx_valid | output | 1 | Response byte present |
| tx_data | output | 8 | Response byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| touch_state | input | 32 | Per-key touch flags, index Y*8+X |
| key_error | input | 32 | Per-key fault flags, index Y*8+X |
| key_sel | output | 5 | Per-key lookup index {Y,X} |
| key_ref | input | 8 | Reference level of selected key |
| key_sig | input | 8 | Signal level of selected key |
| key_offset | input | 8 | Fine offset of selected key |
| key_coarse | input | 2 | Coarse cancel steps of selected key |
| recal_req | output | 1 | One-cycle request to recalibrate all keys |
| out_pins | output | 8 | General-purpose output pins |
| in_pins | input | 4 | General-purpose input pins |

## Verification
A parser left in the wrong state shows up on the first later command. It either emits bytes the host did not ask for or swallows the next command's lead byte, so the byte queue at tx_data differs within a few cycles of that command's last byte. A wrong table write is only visible when that address is read back, so each write is paired with a later read. A lost or stray recalibration request is caught by counting recal_req pulses against the gain writes issued. Timeout faults are exposed by gaps just short of and well past the limit.

// File: rtl/keypad_cmd_handler.sv
module keypad_cmd_handler #(
  parameter int         TIMEOUT_CYCLES = 1000,
  parameter int         FIFO_DEPTH     = 16,
  parameter logic [7:0] REV_HI         = 8'h30,
  parameter logic [7:0] REV_LO         = 8'h31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  input  logic [31:0] touch_state,
  input  logic [31:0] key_error,
  output logic [4:0]  key_sel,
  input  logic [7:0]  key_ref,
  input  logic [7:0]  key_sig,
  input  logic [7:0]  key_offset,
  input  logic [1:0]  key_coarse,
  output logic        recal_req,
  output logic [7:0]  out_pins,
  input  logic [3:0]  in_pins
);
  localparam int AW      = $clog2(FIFO_DEPTH);
  localparam int TW      = $clog2(TIMEOUT_CYCLES) + 1;
  localparam int MAX_RSP = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SLASH, ST_RDX, ST_RDY, ST_CALX, ST_CALY,
    ST_MRD, ST_MWA, ST_MWV, ST_PORT
  } st_t;

  st_t         st;
  logic [2:0]  x_q;
  logic [7:0]  a_q;
  logic [TW-1:0] tmo;
  logic [7:0]  mem [256];
  logic [7:0]  fifo [FIFO_DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] cnt;
  logic [7:0]  rsp [MAX_RSP];
  logic [2:0]  rsp_len;
  logic        acc, pop, is_gain;

  assign acc      = rx_valid && rx_ready;
  assign pop      = tx_valid && tx_ready;
  assign rx_ready = int'(cnt) <= FIFO_DEPTH - MAX_RSP;
  assign tx_valid = cnt != '0;
  assign tx_data  = fifo[rp];
  assign key_sel  = {rx_data[1:0], x_q};
  assign is_gain  = (a_q >= 8'd100) && (a_q <= 8'd162) && !a_q[0];

  always_comb begin
    for (int i = 0; i < MAX_RSP; i++) rsp[i] = 8'h00;
    rsp_len = 3'd0;
    if (acc) begin
      case (st)
        ST_IDLE: begin
          case (rx_data)
            8'h73: begin
              for (int k = 0; k < 4; k++) rsp[k] = touch_state[8*k +: 8];
              rsp_len = 3'd4;
            end
            8'h65: begin
              for (int k = 0; k < 4; k++) rsp[k] = key_error[8*k +: 8];
              rsp_len = 3'd4;
            end
            8'h53: begin
              rsp[0] = 8'h33; rsp[1] = 8'h32; rsp[2] = 8'h30;
              rsp[3] = 8'h30; rsp[4] = 8'h30; rsp[5] = REV_HI; rsp[6] = REV_LO;
              rsp_len = 3'd7;
            end
            8'h49: begin
              rsp[0] = {4'b0000, in_pins};
              rsp_len = 3'd1;
            end
            default: rsp_len = 3'd0;
          endcase
        end
        ST_RDY: begin
          rsp[0] = key_ref; rsp[1] = key_sig; rsp_len = 3'd2;
        end
        ST_CALY: begin
          rsp[0] = key_offset; rsp[1] = {6'b000000, key_coarse}; rsp_len = 3'd2;
        end
        ST_MRD: begin
          rsp[0] = mem[rx_data]; rsp_len = 3'd1;
        end
        default: rsp_len = 3'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < MAX_RSP; i++)
      if (i < int'(rsp_len)) fifo[wp + AW'(i)] <= rsp[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      x_q       <= '0;
      a_q       <= '0;
      tmo       <= '0;
      out_pins  <= '0;
      recal_req <= 1'b0;
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else begin
      recal_req <= 1'b0;
      if (acc) begin
        tmo <= '0;
        case (st)
          ST_IDLE: begin
            if (rx_data == 8'h2F)      st <= ST_SLASH;
            else if (rx_data == 8'h4F) st <= ST_PORT;
          end
          ST_SLASH: begin
            case (rx_data)
              8'h64:   st <= ST_RDX;
              8'h44:   st <= ST_CALX;
              8'h65:   st <= ST_MRD;
              8'h45:   st <= ST_MWA;
              default: st <= ST_IDLE;
            endcase
          end
          ST_RDX:  begin x_q <= rx_data[2:0]; st <= ST_RDY;  end
          ST_CALX: begin x_q <= rx_data[2:0]; st <= ST_CALY; end
          ST_MWA:  begin a_q <= rx_data;      st <= ST_MWV;  end
          ST_MWV: begin
            mem[a_q]  <= rx_data;
            recal_req <= is_gain;
            st        <= ST_IDLE;
          end
          ST_PORT: begin out_pins <= rx_data; st <= ST_IDLE; end
          default: st <= ST_IDLE;
        endcase
      end else if (st != ST_IDLE) begin
        if (tmo == TW'(TIMEOUT_CYCLES - 1)) begin
          st  <= ST_IDLE;
          tmo <= '0;
        end else begin
          tmo <= tmo + 1'b1;
        end
      end
      wp  <= wp + AW'(rsp_len);
      if (pop) rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(rsp_len) - (AW+1)'(pop);
    end
  end
endmodule

// File: rtl/keypad_cmd_handler_chk.sv
module keypad_cmd_handler_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int CW         = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          recal_req,
  input logic [7:0]    out_pins,
  input logic [CW-1:0] fifo_cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= FIFO_DEPTH); // R12
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R12
  AST_RECAL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |-> $past(rx_valid && rx_ready)); // R8
  AST_RECAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |=> !recal_req); // R8
  AST_PINS_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_ready) |=> $stable(out_pins)); // R9
endmodule

bind keypad_cmd_handler keypad_cmd_handler_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .CW($clog2(FIFO_DEPTH) + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .recal_req(recal_req), .out_pins(out_pins), .fifo_cnt(cnt)
);

// File: tb/test_keypad_cmd_handler.sv
module test_keypad_cmd_handler;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_valid, rx_ready, tx_valid, tx_ready, recal_req;
  logic [7:0] rx_data, tx_data, out_pins, key_ref, key_sig, key_offset;
  logic [31:0] touch_state, key_error;
  logic [4:0] key_sel;
  logic [1:0] key_coarse;
  logic [3:0] in_pins;

  int checks = 0, errors = 0, cyc = 0, recal_cnt = 0, stall_mode = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  keypad_cmd_handler #(.TIMEOUT_CYCLES(TMO), .FIFO_DEPTH(16)) i_keypad_cmd_handler (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .touch_state(touch_state), .key_error(key_error), .key_sel(key_sel),
    .key_ref(key_ref), .key_sig(key_sig), .key_offset(key_offset), .key_coarse(key_coarse),
    .recal_req(recal_req), .out_pins(out_pins), .in_pins(in_pins)
  );

  function automatic logic [7:0] m_ref(input logic [4:0] k); return {3'b000, k} + 8'd60; endfunction
  function automatic logic [7:0] m_sig(input logic [4:0] k); return {3'b000, k} ^ 8'hA5; endfunction
  function automatic logic [7:0] m_off(input logic [4:0] k); return {k, 3'b101}; endfunction
  function automatic logic [1:0] m_crs(input logic [4:0] k);
    case (k % 3) 0: return 2'd0; 1: return 2'd1; default: return 2'd3; endcase
  endfunction

  always_comb begin
    key_ref = m_ref(key_sel); key_sig = m_sig(key_sel);
    key_offset = m_off(key_sel); key_coarse = m_crs(key_sel);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: got %0h expected %0h", tag, act, exp); end
  endtask

  task automatic expect_b(input logic [7:0] b, input string tag);
    exp_q.push_back(b); tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    cyc++;
    tx_ready = (stall_mode == 0) || (stall_mode == 1 && (cyc % 3) != 0);
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 R12 unexpected byte", tx_data, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(tx_data == e, t, tx_data, e);
      end
    end
    if (rst_n && recal_req) recal_cnt++;
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmd_state(input string tag);
    send(8'h73);
    for (int k = 0; k < 4; k++) expect_b(touch_state[8*k +: 8], tag);
  endtask

  task automatic cmd_data(input logic [7:0] x, input logic [7:0] y);
    automatic logic [4:0] k = {y[1:0], x[2:0]};
    send(8'h2F); send(8'h64); send(x);
    expect_b(m_ref(k), "R5 ref"); expect_b(m_sig(k), "R5 sig");
    send(y);
  endtask

  task automatic cmd_cal(input logic [7:0] x, input logic [7:0] y);
    automatic logic [4:0] k = {y[1:0], x[2:0]};
    send(8'h2F); send(8'h44); send(x);
    expect_b(m_off(k), "R6 offset"); expect_b({6'b0, m_crs(k)}, "R6 coarse");
    send(y);
  endtask

  task automatic mem_wr(input logic [7:0] a, input logic [7:0] v);
    send(8'h2F); send(8'h45); send(a); send(v);
  endtask

  task automatic mem_rd(input logic [7:0] a, input logic [7:0] v, input string tag);
    send(8'h2F); send(8'h65);
    expect_b(v, tag);
    send(a);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int exp_recal;
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = 8'h00; in_pins = 4'hA;
    touch_state = 32'h8001_2410; key_error = 32'h0000_0003;
    repeat (4) @(negedge clk);
    chk(tx_valid == 1'b0, "R1 tx_valid in reset", tx_valid, 0);
    chk(out_pins == 8'h00, "R1 out_pins in reset", out_pins, 0);
    chk(recal_req == 1'b0, "R1 recal in reset", recal_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready == 1'b1, "R1 rx_ready after reset", rx_ready, 1);
    mem_rd(8'd0, 8'h00, "R1 memory zero at 0");
    mem_rd(8'd255, 8'h00, "R1 memory zero at 255");

    cmd_state("R2 touch bytes A");
    touch_state = 32'h00FF_0000; drain();
    cmd_state("R2 touch bytes B");
    drain();

    send(8'h65);
    for (int k = 0; k < 4; k++) expect_b(key_error[8*k +: 8], "R3 error bytes");
    send(8'h53);
    expect_b(8'h33, "R4 sig"); expect_b(8'h32, "R4 sig");
    for (int k = 0; k < 3; k++) expect_b(8'h30, "R4 sig");
    expect_b(8'h30, "R4 rev hi"); expect_b(8'h31, "R4 rev lo");

    cmd_data(8'hFB, 8'h05);
    cmd_data(8'h00, 8'h00);
    cmd_data(8'h07, 8'h03);
    cmd_cal(8'h02, 8'h00);
    cmd_cal(8'h01, 8'h00);
    cmd_cal(8'h00, 8'h03);
    drain();

    exp_recal = 0;
    mem_wr(8'd138, 8'h22); exp_recal++; repeat (2) @(negedge clk);
    chk(recal_cnt == exp_recal, "R8 gain write 138 pulses", recal_cnt, exp_recal);
    mem_wr(8'd139, 8'h33); repeat (2) @(negedge clk);
    chk(recal_cnt == exp_recal, "R8 threshold write no pulse", recal_cnt, exp_recal);
    mem_wr(8'd200, 8'h77); repeat (2) @(negedge clk);
    chk(recal_cnt == exp_recal, "R8 user write no pulse", recal_cnt, exp_recal);
    mem_wr(8'd100, 8'h11); exp_recal++; repeat (2) @(negedge clk);
    chk(recal_cnt == exp_recal, "R8 gain write 100 pulses", recal_cnt, exp_recal);
    mem_wr(8'd162, 8'h44); exp_recal++; repeat (2) @(negedge clk);
    chk(recal_cnt == exp_recal, "R8 gain write 162 pulses", recal_cnt, exp_recal);
    mem_wr(8'd164, 8'h55); repeat (2) @(negedge clk);
    chk(recal_cnt == exp_recal, "R8 write 164 no pulse", recal_cnt, exp_recal);
    mem_rd(8'd138, 8'h22, "R7 read 138");
    mem_rd(8'd139, 8'h33, "R7 read 139");
    mem_rd(8'd200, 8'h77, "R7 read 200");
    mem_rd(8'd164, 8'h55, "R7 read 164");
    drain();

    send(8'h4F); send(8'h5A);
    chk(out_pins == 8'h5A, "R9 out_pins", out_pins, 8'h5A);
    send(8'h49); expect_b(8'h0A, "R9 input read A");
    in_pins = 4'h5;
    send(8'h49); expect_b(8'h05, "R9 input read 5");
    drain();

    send(8'h41);
    send(8'h2F); send(8'h99);
    cmd_state("R10 command after junk");
    drain();
    chk(tx_valid == 1'b0, "R10 no extra bytes", tx_valid, 0);

    send(8'h2F);
    repeat (TMO + 16) @(negedge clk);
    cmd_state("R11 new command after timeout");
    drain();
    send(8'h2F);
    repeat (TMO / 2) @(negedge clk);
    send(8'h65);
    expect_b(8'h77, "R11 continued before timeout");
    send(8'd200);
    drain();

    stall_mode = 2;
    cmd_state("R12 order under stall");
    cmd_state("R12 order under stall");
    cmd_state("R12 order under stall");
    chk(rx_ready == 1'b0, "R12 rx_ready low when queue full", rx_ready, 0);
    chk(tx_valid == 1'b1, "R12 tx_valid held under stall", tx_valid, 1);
    stall_mode = 1;
    drain();
    send(8'h53);
    expect_b(8'h33, "R12 sig under pacing"); expect_b(8'h32, "R12 sig under pacing");
    for (int k = 0; k < 3; k++) expect_b(8'h30, "R12 sig under pacing");
    expect_b(8'h30, "R12 sig under pacing"); expect_b(8'h31, "R12 sig under pacing");
    drain();
    stall_mode = 0;
    chk(exp_q.size() == 0, "R12 all responses delivered", exp_q.size(), 0);
    summary();
  end
endmodule